// File: doc/BRIEF.md
# Serial IRQ Routing Matrix

This block steers interrupt lines from a set of logical devices onto sixteen host interrupt slots, IRQ0 through IRQ15. Every device offers up to two interrupt lines. Each slot owns an 8-bit routing register. The register names one source device by its logical-device number and chooses that device's first or second line. The registered output is a 16-bit level vector, one bit per slot. A serial IRQ serializer placed after this block consumes that vector.

Firmware or the host programs the routing registers and one global mode register through a byte-wide indexed configuration port. A slot can be switched off in two ways. Setting its device bit switches it off; the all-ones value does this and is also the reset value. Pointing it at a source that does not exist also leaves it inactive. A global enable bit can silence every slot at once.

Top module: `irqrt_matrix`

## Requirements
- R1: After reset every routing register reads FFh, the mode register reads 04h, and `irq_out` is all zero.
- R2: Routing register fields are: bit 7 line select, bit 6 device-disable bit, bits 5:0 source logical-device number. For example, 01h on slot 1 carries device 1's first line, 81h on slot 12 carries device 1's second line, and 07h on slot 4 carries device 7's first line.
- R3: A slot whose routing register has bit 6 set drives 0, whatever its other bits and the source levels are.
- R4: With bit 7 clear a slot carries the source's first line (`src_lvl[2*n]`). With bit 7 set it carries the second line (`src_lvl[2*n+1]`), where n is the source number.
- R5: Slot outputs are levels. Each is registered once, so `irq_out` shows the source and routing state sampled at the previous rising clock edge.
- R6: Mode register index 24h bit 2 is the global enable, and it resets to 1. When it is 0, all of `irq_out` is 0. Its other bits read 0 and ignore writes.
- R7: Implemented sources are devices 00h, 01h, 03h, 04h, 07h, 09h, 0Ah, 0Bh and 0Ch. Only 00h, 01h and 09h have a second line. A slot drives 0 in either case: its source number is not implemented, or it selects the second line of a single-line source.
- R8: Writes to any index other than 24h and 40h–4Fh change no state. Reads of such indices return FFh.
- R9: Routing register for slot s lives at index 40h+s. `cfg_rdata` returns the value last written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_idx | input | 8 | Register index for read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_idx` |
| src_lvl | input | 46 | Source lines, two per device: bit 2n first line, bit 2n+1 second line |
| irq_out | output | 16 | Registered slot levels |

## Verification
The bench sweeps all 256 routing values through every slot against two source patterns. This reaches the corner cases of the decoder: a frame number beyond the implemented range, a gap in the device list, a second-line select on a single-line device, and a set device bit combined with a valid frame. Each of these would show up as a spurious asserted slot if handled wrongly. A wrong index decode would show as a write landing in a neighbouring slot or a write into reserved space being honoured. The bench also checks that the output lags the source by exactly one edge, and that clearing the global enable silences slots that are otherwise routed and high.

// File: rtl/irqrt_pkg.sv
package irqrt_pkg;

    localparam int           IDX_W      = 8;
    localparam int           FRAME_W    = 6;
    localparam logic [7:0]   SLOT_BASE  = 8'h40;
    localparam logic [7:0]   MODE_IDX   = 8'h24;
    localparam int           EN_BIT     = 2;
    localparam logic [7:0]   ROUTE_OFF  = 8'hFF;
    localparam logic [7:0]   UNMAPPED_RD = 8'hFF;

    // Default source population: 23 device numbers (00h..16h)
    localparam int           DEF_DEVS   = 23;
    localparam logic [22:0]  DEF_IMPL   = 23'h001E9B;
    localparam logic [22:0]  DEF_DUAL   = 23'h000203;

    typedef struct packed {
        logic               sel;    // bit 7: second line
        logic               dev;    // bit 6: disable when set
        logic [FRAME_W-1:0] frame;  // bits 5:0: source number
    } route_t;

    function automatic logic [7:0] mode_readback(logic en);
        logic [7:0] v;
        v = '0;
        v[EN_BIT] = en;
        return v;
    endfunction

endpackage

// File: rtl/irqrt_cfg_regs.sv
module irqrt_cfg_regs
    import irqrt_pkg::*;
#(
    parameter int SLOTS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    output route_t           route_o [SLOTS],
    output logic             mode_en_o
);

    logic [SLOTS-1:0] hit;
    logic             mode_hit;
    route_t           route_q [SLOTS];
    logic             en_q;

    assign mode_hit = (cfg_idx == MODE_IDX);

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            assign hit[s] = (cfg_idx == IDX_W'(int'(SLOT_BASE) + s));

            always_ff @(posedge clk) begin
                if (rst)
                    route_q[s] <= route_t'(ROUTE_OFF);
                else if (cfg_we && hit[s])
                    route_q[s] <= route_t'(cfg_wdata);
            end

            assign route_o[s] = route_q[s];

            // R1
            rst_val_chk: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> route_q[s] == route_t'(ROUTE_OFF));

            // R9
            wr_take_chk: assert property (@(posedge clk) disable iff (rst)
                (cfg_we && hit[s]) |=> route_q[s] == route_t'($past(cfg_wdata)));

            // R8
            wr_keep_chk: assert property (@(posedge clk) disable iff (rst)
                (cfg_we && !hit[s]) |=> $stable(route_q[s]));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= 1'b1;
        else if (cfg_we && mode_hit)
            en_q <= cfg_wdata[EN_BIT];
    end

    assign mode_en_o = en_q;

    always_comb begin
        cfg_rdata = UNMAPPED_RD;
        if (mode_hit)
            cfg_rdata = mode_readback(en_q);
        for (int s = 0; s < SLOTS; s++) begin
            if (hit[s])
                cfg_rdata = route_q[s];
        end
    end

endmodule

// File: rtl/irqrt_slot_sel.sv
module irqrt_slot_sel
    import irqrt_pkg::*;
#(
    parameter int              DEVS = DEF_DEVS,
    parameter logic [DEVS-1:0] IMPL = DEF_IMPL,
    parameter logic [DEVS-1:0] DUAL = DEF_DUAL
) (
    input  route_t            route,
    input  logic [2*DEVS-1:0] src,
    output logic              lvl
);

    always_comb begin
        lvl = 1'b0;
        if (!route.dev) begin
            for (int d = 0; d < DEVS; d++) begin
                if (route.frame == FRAME_W'(d) && IMPL[d]) begin
                    if (route.sel)
                        lvl = DUAL[d] & src[2*d+1];
                    else
                        lvl = src[2*d];
                end
            end
        end
    end

endmodule

// File: rtl/irqrt_matrix.sv
module irqrt_matrix
    import irqrt_pkg::*;
#(
    parameter int              SLOTS = 16,
    parameter int              DEVS  = DEF_DEVS,
    parameter logic [DEVS-1:0] IMPL  = DEF_IMPL,
    parameter logic [DEVS-1:0] DUAL  = DEF_DUAL
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_idx,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic [2*DEVS-1:0] src_lvl,
    output logic [SLOTS-1:0]  irq_out
);

    route_t           route [SLOTS];
    logic             mode_en;
    logic [SLOTS-1:0] slot_lvl;
    logic [SLOTS-1:0] irq_q;

    irqrt_cfg_regs #(.SLOTS(SLOTS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .route_o   (route),
        .mode_en_o (mode_en)
    );

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_sel
            irqrt_slot_sel #(.DEVS(DEVS), .IMPL(IMPL), .DUAL(DUAL)) u_sel (
                .route (route[s]),
                .src   (src_lvl),
                .lvl   (slot_lvl[s])
            );

            // R3
            dev_off_chk: assert property (@(posedge clk) disable iff (rst)
                route[s].dev |=> !irq_out[s]);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            irq_q <= '0;
        else
            irq_q <= mode_en ? slot_lvl : '0;
    end

    assign irq_out = irq_q;

    // R6
    gen_off_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_en |=> irq_out == '0);

    // R5
    src_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($stable(src_lvl) && !cfg_we && $past(!cfg_we)) |=> $stable(irq_out));

endmodule

// File: tb/irqrt_matrix_bench.sv
`timescale 1ns/1ps
module irqrt_matrix_bench;

    localparam int SLOTS = 16;
    localparam int DEVS  = 23;
    // Population stated in R7
    localparam logic [22:0] IMPL_M = 23'h001E9B;
    localparam logic [22:0] DUAL_M = 23'h000203;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [7:0]        cfg_idx = 8'h00;
    logic [7:0]        cfg_wdata = 8'h00;
    logic [7:0]        cfg_rdata;
    logic [2*DEVS-1:0] src_lvl = '0;
    logic [SLOTS-1:0]  irq_out;

    int total = 0;
    int bad   = 0;
    logic [7:0] shadow [SLOTS];
    logic       en_sh = 1'b1;
    bit         done  = 1'b0;

    always #10 clk = ~clk;

    irqrt_matrix u_irqrt_matrix (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .src_lvl(src_lvl), .irq_out(irq_out)
    );

    function automatic logic slot_exp(logic [7:0] v, logic [2*DEVS-1:0] s, logic en);
        int f;
        f = int'(v[5:0]);
        if (!en || v[6]) return 1'b0;
        if (f >= DEVS) return 1'b0;
        if (!IMPL_M[f]) return 1'b0;
        if (v[7]) return DUAL_M[f] & s[2*f+1];
        return s[2*f];
    endfunction

    function automatic logic [SLOTS-1:0] vec_exp(logic [2*DEVS-1:0] s);
        logic [SLOTS-1:0] r;
        for (int k = 0; k < SLOTS; k++) r[k] = slot_exp(shadow[k], s, en_sh);
        return r;
    endfunction

    function automatic logic [2*DEVS-1:0] pat_b(int v);
        logic [2*DEVS-1:0] p;
        for (int i = 0; i < 2*DEVS; i++) p[i] = (((i * 7) + v) % 3) == 0;
        return p;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] idx, logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [7:0] idx, logic [7:0] exp);
        cfg_idx = idx;
        #1;
        chk(req, 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic drive_chk(string req, logic [2*DEVS-1:0] s);
        src_lvl = s;
        @(negedge clk);
        chk(req, 32'(irq_out), 32'(vec_exp(s)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < SLOTS; k++) shadow[k] = 8'hFF;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset values
        for (int k = 0; k < SLOTS; k++) rd_chk("R1 route reset", 8'(8'h40 + k), 8'hFF);
        rd_chk("R1 mode reset", 8'h24, 8'h04);
        src_lvl = '1;
        @(negedge clk);
        chk("R1 outputs idle", 32'(irq_out), 32'h0);

        // R2: example routings
        wr(8'h41, 8'h01); shadow[1] = 8'h01;
        wr(8'h4C, 8'h81); shadow[12] = 8'h81;
        wr(8'h44, 8'h07); shadow[4] = 8'h07;
        drive_chk("R2 kbd first", 46'(1) << 2);
        chk("R2 slot1 high", 32'(irq_out), 32'h0002);
        drive_chk("R2 kbd second", 46'(1) << 3);
        chk("R2 slot12 high", 32'(irq_out), 32'h1000);
        drive_chk("R2 uart", 46'(1) << 14);
        chk("R2 slot4 high", 32'(irq_out), 32'h0010);

        // R5: one-edge latency, level following
        src_lvl = 46'(1) << 2;
        #1;
        chk("R5 no change before edge", 32'(irq_out), 32'h0010);
        @(negedge clk);
        chk("R5 follows after edge", 32'(irq_out), 32'h0002);
        @(negedge clk);
        chk("R5 level held", 32'(irq_out), 32'h0002);
        drive_chk("R5 drop", '0);

        // R6: global enable
        wr(8'h24, 8'h00); en_sh = 1'b0;
        rd_chk("R6 mode cleared", 8'h24, 8'h00);
        drive_chk("R6 gated off", '1);
        chk("R6 all zero", 32'(irq_out), 32'h0);
        wr(8'h24, 8'hFF); en_sh = 1'b1;
        rd_chk("R6 reserved bits zero", 8'h24, 8'h04);
        drive_chk("R6 reenabled", '1);
        chk("R6 routed high", 32'(irq_out), 32'h1012);

        // R8: unmapped writes change nothing
        wr(8'h50, 8'h01);
        wr(8'h3F, 8'h00);
        wr(8'h23, 8'h00);
        rd_chk("R8 unmapped read 50h", 8'h50, 8'hFF);
        rd_chk("R8 unmapped read 3Fh", 8'h3F, 8'hFF);
        for (int k = 0; k < SLOTS; k++) rd_chk("R8 routes kept", 8'(8'h40 + k), shadow[k]);
        rd_chk("R8 mode kept", 8'h24, 8'h04);
        drive_chk("R8 outputs kept", '1);

        for (int k = 0; k < SLOTS; k++) begin
            wr(8'(8'h40 + k), 8'hFF); shadow[k] = 8'hFF;
        end

        // R3 R4 R7 R9: full sweep of every value through every slot
        for (int k = 0; k < SLOTS; k++) begin
            for (int v = 0; v < 256; v++) begin
                wr(8'(8'h40 + k), 8'(v)); shadow[k] = 8'(v);
                rd_chk("R9 readback", 8'(8'h40 + k), 8'(v));
                drive_chk("R3 R4 R7 sweep ones", '1);
                drive_chk("R3 R4 R7 sweep pattern", pat_b(v + k));
            end
            wr(8'(8'h40 + k), 8'hFF); shadow[k] = 8'hFF;
        end
        drive_chk("R3 all off", '1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule